// File: doc/BRIEF.md
# Mode-Configurable Dual-Port RAM Block

This block is a 2,304-bit synchronous memory with one write port and one read port. Each port has its own clock, address, enable and chip-select. A two-bit static mode input chooses how the storage is organised: either 128 words of 18 bits or 256 words of 9 bits. The same physical cells are used under both organisations, so the block can hold working data, constants loaded at start-up, or the storage of a queue built around it.

Blocks can be joined together. For more width, several blocks share the address and enables, and each one carries its own slice of the data. For more depth, each block gets its own chip-select from a higher address decode. A block that was not selected on its last read drives all-zero read data, so the read buses of the joined blocks can simply be ORed together.

Top module: `dpram_cfg_block`

## Requirements
- R1: With mode 2'b00 the block is 128 words of 18 bits. Row = addr[6:0], addr[7] is ignored, so addresses 8'h05 and 8'h85 reach the same word.
- R2: With mode 2'b01 the block is 256 words of 9 bits. Row = addr[7:1]. addr[0]=1 selects the upper half of the row (bits 17:9) and addr[0]=0 selects the lower half (bits 8:0).
- R3: A 9-bit write changes only the selected half of its 18-bit row. The other half keeps its contents, which can be seen through an 18-bit read of that row after the mode is changed.
- R4: A 9-bit read returns the selected half on rdata[8:0] and zero on rdata[17:9].
- R5: Storage changes on a wclk rising edge only when we=1 and wcs=1 at that edge. A write with either of them low leaves every word unchanged.
- R6: A read with re=1 and rcs=1 at an rclk rising edge presents the addressed word on rdata just after that edge (one cycle of latency).
- R7: A read with re=1 and rcs=0 drives rdata to all zeros after the edge.
- R8: While re=0, rdata holds its previous value.
- R9: When both ports use the same row on the same edge of a shared clock, the read returns the data stored before the write.
- R10: While rst_n is low, and after it is released until the first read, rdata is zero.
- R11: Mode encodings 2'b10 and 2'b11 behave exactly as 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write port clock |
| rclk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read output stage |
| mode | input | 2 | Organisation select (2'b01 = 256x9, others = 128x18) |
| we | input | 1 | Write enable |
| wcs | input | 1 | Write chip-select |
| waddr | input | 8 | Write address |
| wdata | input | 18 | Write data (bits 8:0 only in 9-bit mode) |
| re | input | 1 | Read enable |
| rcs | input | 1 | Read chip-select |
| raddr | input | 8 | Read address |
| rdata | output | 18 | Registered read data |

## Verification
A write becomes visible at the first rclk edge that follows the wclk edge where it was accepted. Read data, the zero output of a deselected read, and the held value while re is low all appear exactly one rclk edge after the request. The bench ties both clocks to one source. It drives every input at a falling edge and compares rdata at the next falling edge, so each comparison sits exactly one rising edge after its stimulus. Its reference model applies the read before the write in each cycle, which gives the old-data result for a same-row access.

// File: rtl/dpram_cfg_pkg.sv
package dpram_cfg_pkg;

    typedef enum logic [1:0] {
        ORG_WIDE    = 2'b00,
        ORG_NARROW  = 2'b01,
        ORG_SPARE_A = 2'b10,
        ORG_SPARE_B = 2'b11
    } org_mode_e;

    // Only the narrow encoding changes the organisation; all others are wide.
    function automatic logic org_is_narrow(input logic [1:0] mode);
        return mode == ORG_NARROW;
    endfunction

endpackage

// File: rtl/dpram_addr_map.sv
module dpram_addr_map #(
    parameter int ROW_AW = 7
) (
    input  logic [1:0]        mode,
    input  logic [ROW_AW:0]   addr,
    input  logic              en,
    output logic [ROW_AW-1:0] row,
    output logic [1:0]        lane_en
);
    import dpram_cfg_pkg::*;

    logic narrow;

    always_comb begin
        narrow = org_is_narrow(mode);
        if (narrow) begin
            row     = addr[ROW_AW:1];
            lane_en = en ? (addr[0] ? 2'b10 : 2'b01) : 2'b00;
        end else begin
            row     = addr[ROW_AW-1:0];
            lane_en = en ? 2'b11 : 2'b00;
        end
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 128,
    localparam int HALF_W = DATA_W / 2,
    localparam int ROW_AW = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic [ROW_AW-1:0] w_row,
    input  logic [1:0]        w_lanes,
    input  logic [DATA_W-1:0] w_data,
    input  logic              rclk,
    input  logic              rd_en,
    input  logic [ROW_AW-1:0] r_row,
    output logic [DATA_W-1:0] r_data
);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HALF_W-1:0] lane_mem [DEPTH];
        logic [HALF_W-1:0] lane_rd_q;

        always_ff @(posedge wclk) begin
            if (w_lanes[g]) begin
                lane_mem[w_row] <= w_data[g*HALF_W +: HALF_W];
            end
        end

        // Sampled with nonblocking semantics: a same-edge write is not seen.
        always_ff @(posedge rclk) begin
            if (rd_en) begin
                lane_rd_q <= lane_mem[r_row];
            end
        end

        assign r_data[g*HALF_W +: HALF_W] = lane_rd_q;
    end

endmodule

// File: rtl/dpram_rd_align.sv
module dpram_rd_align #(
    parameter int DATA_W = 18,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [1:0]        lane_en,
    input  logic [DATA_W-1:0] row_data,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [1:0] lanes;
    } rd_stage_t;

    rd_stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.lanes = lane_en;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.lanes)
            2'b11:   rdata = row_data;
            2'b01:   rdata = {{HALF_W{1'b0}}, row_data[HALF_W-1:0]};
            2'b10:   rdata = {{HALF_W{1'b0}}, row_data[DATA_W-1:HALF_W]};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dpram_cfg_block.sv
module dpram_cfg_block #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 128,
    localparam int HALF_W = DATA_W / 2,
    localparam int ROW_AW = $clog2(DEPTH),
    localparam int ADDR_W = ROW_AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              we,
    input  logic              wcs,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              rcs,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    import dpram_cfg_pkg::*;

    logic [ROW_AW-1:0] w_row, r_row;
    logic [1:0]        w_lanes, r_lanes;
    logic [DATA_W-1:0] w_row_data, r_row_data;

    dpram_addr_map #(.ROW_AW(ROW_AW)) u_wmap (
        .mode    (mode),
        .addr    (waddr),
        .en      (we && wcs),
        .row     (w_row),
        .lane_en (w_lanes)
    );

    dpram_addr_map #(.ROW_AW(ROW_AW)) u_rmap (
        .mode    (mode),
        .addr    (raddr),
        .en      (re && rcs),
        .row     (r_row),
        .lane_en (r_lanes)
    );

    // In the narrow organisation the 9-bit word is offered to both lanes;
    // the lane enables decide which half is written.
    assign w_row_data = org_is_narrow(mode) ? {2{wdata[HALF_W-1:0]}} : wdata;

    dpram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .wclk    (wclk),
        .w_row   (w_row),
        .w_lanes (w_lanes),
        .w_data  (w_row_data),
        .rclk    (rclk),
        .rd_en   (re),
        .r_row   (r_row),
        .r_data  (r_row_data)
    );

    dpram_rd_align #(.DATA_W(DATA_W)) u_align (
        .rclk     (rclk),
        .rst_n    (rst_n),
        .re       (re),
        .lane_en  (r_lanes),
        .row_data (r_row_data),
        .rdata    (rdata)
    );

endmodule

// File: rtl/dpram_cfg_block_chk.sv
module dpram_cfg_block_chk #(
    parameter int DATA_W = 18,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              rclk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              re,
    input logic              rcs,
    input logic [DATA_W-1:0] rdata
);

    AST_DESELECT_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
        (re && !rcs) |=> rdata == '0); // R7

    AST_IDLE_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rdata)); // R8

    AST_NARROW_TOP_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
        (re && mode == 2'b01) |=> rdata[DATA_W-1:HALF_W] == '0); // R4

    AST_RESET_CLEAR: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> rdata == '0); // R10

endmodule

bind dpram_cfg_block dpram_cfg_block_chk #(.DATA_W(DATA_W)) u_chk (
    .rclk  (rclk),
    .rst_n (rst_n),
    .mode  (mode),
    .re    (re),
    .rcs   (rcs),
    .rdata (rdata)
);

// File: tb/dpram_cfg_block_tb.sv
module dpram_cfg_block_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        we, wcs, re, rcs;
    logic [7:0]  waddr, raddr;
    logic [17:0] wdata;
    logic [17:0] rdata;

    logic [17:0] ref_mem [128];
    logic [17:0] exp_rd;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dpram_cfg_block u_dut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .mode(mode),
        .we(we), .wcs(wcs), .waddr(waddr), .wdata(wdata),
        .re(re), .rcs(rcs), .raddr(raddr), .rdata(rdata)
    );

    function automatic bit nar(input logic [1:0] m);
        return m == 2'b01;
    endfunction

    function automatic logic [17:0] model_read(input logic [1:0] m, input logic [7:0] a);
        logic [17:0] w;
        if (nar(m)) begin
            w = ref_mem[a[7:1]];
            return a[0] ? {9'b0, w[17:9]} : {9'b0, w[8:0]};
        end
        return ref_mem[a[6:0]];
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; checks one rising edge later.
    task automatic step(input logic [1:0] m, input logic we_i, input logic wcs_i,
                        input logic [7:0] wa, input logic [17:0] wd,
                        input logic re_i, input logic rcs_i, input logic [7:0] ra,
                        input string tag);
        mode = m; we = we_i; wcs = wcs_i; waddr = wa; wdata = wd;
        re = re_i; rcs = rcs_i; raddr = ra;
        if (re_i) exp_rd = rcs_i ? model_read(m, ra) : 18'h0;
        if (we_i && wcs_i) begin
            if (nar(m)) begin
                if (wa[0]) ref_mem[wa[7:1]][17:9] = wd[8:0];
                else       ref_mem[wa[7:1]][8:0]  = wd[8:0];
            end else begin
                ref_mem[wa[6:0]] = wd;
            end
        end
        @(negedge clk);
        check(tag, rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mode = 2'b00; we = 0; wcs = 0; re = 0; rcs = 0;
        waddr = 0; raddr = 0; wdata = 0; exp_rd = 18'h0;
        repeat (3) @(negedge clk);
        check("R10 in reset", rdata, 18'h0);
        rst_n = 1'b1;
        step(2'b00, 0, 0, 8'h00, 18'h0, 0, 1, 8'h00, "R10 after release");

        // Fill every row through the wide view.
        for (int i = 0; i < 128; i++)
            step(2'b00, 1, 1, 8'(i), 18'((i * 18'h0a5b) ^ 18'h3c3c3), 0, 0, 8'h00, "R5 fill");

        // R1: addr[7] aliases in the wide view.
        step(2'b00, 1, 1, 8'h85, 18'h2abcd, 0, 0, 8'h00, "R1 write");
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h05, "R1 read alias");
        check("R1 alias value", rdata, 18'h2abcd);
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h85, "R1 read high");

        // R2/R3/R4: narrow upper write keeps lower half.
        step(2'b01, 1, 1, 8'h0b, 18'h3f1aa, 0, 0, 8'h00, "R3 narrow write");
        step(2'b01, 0, 0, 8'h00, 18'h0, 1, 1, 8'h0b, "R2 narrow upper read");
        check("R4 narrow upper value", rdata, 18'h001aa);
        step(2'b01, 0, 0, 8'h00, 18'h0, 1, 1, 8'h0a, "R2 narrow lower read");
        check("R2 lower half", rdata, {9'b0, 9'h1cd});
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h05, "R3 wide view of narrow write");
        check("R3 combined row", rdata, {9'h1aa, 9'h1cd});

        // R9: same row, same edge returns the old data.
        step(2'b00, 1, 1, 8'h07, 18'h15555, 1, 1, 8'h07, "R9 collision old data");
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h07, "R9 new data next read");
        check("R9 new value", rdata, 18'h15555);

        // R5: gated writes change nothing.
        step(2'b00, 1, 0, 8'h09, 18'h00001, 0, 0, 8'h00, "R5 wcs low");
        step(2'b00, 0, 1, 8'h09, 18'h00002, 0, 0, 8'h00, "R5 we low");
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h09, "R5 row unchanged");

        // R7, R8.
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 0, 8'h09, "R7 deselected zero");
        check("R7 zero", rdata, 18'h0);
        step(2'b00, 0, 0, 8'h00, 18'h0, 1, 1, 8'h12, "R6 read");
        step(2'b00, 1, 1, 8'h12, 18'h0ffff, 0, 1, 8'h12, "R8 hold while idle");
        step(2'b00, 0, 0, 8'h00, 18'h0, 0, 1, 8'h33, "R8 hold again");

        // R11: spare encodings act wide.
        step(2'b11, 1, 1, 8'h83, 18'h3a5a5, 0, 0, 8'h00, "R11 write mode 3");
        step(2'b10, 0, 0, 8'h00, 18'h0, 1, 1, 8'h03, "R11 read mode 2");
        check("R11 full width", rdata, 18'h3a5a5);

        // Random phases, one per mode encoding.
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 400; n++) begin
                logic [7:0] wa, ra;
                logic w, ws, r, rs;
                string tag;
                wa = 8'($urandom);
                ra = ($urandom % 4 == 0) ? wa : 8'($urandom);
                w = 1'($urandom); ws = ($urandom % 4) != 0;
                r = ($urandom % 5) != 0; rs = ($urandom % 5) != 0;
                if (!r)        tag = "R8 random hold";
                else if (!rs)  tag = "R7 random deselect";
                else if (p == 1) tag = "R4 random narrow";
                else if (p >= 2) tag = "R11 random spare";
                else             tag = "R6 random wide";
                step(2'(p), w, ws, wa, 18'($urandom), r, rs, ra, tag);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule